// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns an addressing-mode code, an operand size, register selects, one extension word and the program counter into the operand address of a processor with 24-bit addresses. It covers eleven mode codes: immediate, register direct, long and short absolute, register indirect, post-increment, pre-decrement, and displacement forms. The displacement forms pair a 16-bit or an 8-bit signed displacement with either an address register or the PC. The 8-bit forms also add an index register. All arithmetic wraps at 2^24.

The unit holds eight address registers and eight data registers, each 24 bits wide. A data register is only ever read as an index here, so only its low 24 bits matter. Two modes change a register: post-increment and pre-decrement. In those modes the unit presents the new register value with a write strobe. The write strobe is gated by the access-done input, and the register takes the value on that same clock edge. A separate load port lets the surrounding datapath set any register.

Top module: `eagu_top`

## Requirements
- R1: After reset every address and data register reads as zero.
- R2: In immediate (mode 0), register direct (mode 3) and unused codes 11 to 15, `mem_o` is 0, `ea_o` is 0 and `wb_en_o` is 0. In modes 1, 2 and 4 to 10, `mem_o` is 1.
- R3: Mode 1 gives `ea_o = ext_i`. Mode 2 gives `ext_i[15:0]` on bits 15:0, with bit 15 copied into bits 23:16.
- R4: Mode 4 gives the address register chosen by `reg_sel_i` and leaves every register unchanged.
- R5: Mode 5 gives the register's current value as the address. `wb_val_o` is that value plus the size step (size code 0 → 1, 1 → 2, 2 or 3 → 4).
- R6: Mode 6 gives the register value minus the size step as both `ea_o` and `wb_val_o`.
- R7: Mode 7 adds the sign-extended `ext_i[15:0]` to the selected address register. Mode 9 adds it to `pc_i`.
- R8: Mode 8 adds the sign-extended `ext_i[7:0]`, the selected address register and the index register. Mode 10 adds the same displacement, `pc_i` and the index register. For the index select, bit 3 set means data register and clear means address register, and bits 2:0 give the register number.
- R9: Every sum and difference wraps modulo 2^24.
- R10: `wb_en_o` is 1 only in modes 5 and 6 while `done_i` is 1. `wb_reg_o` equals `reg_sel_i`. The register takes `wb_val_o` on that clock edge, and with `done_i` low it is untouched.
- R11: With `ld_en_i` high, `ld_data_i` is written on the clock edge to the register chosen by `ld_sel_i` (same encoding as the index select). A load to the same address register as a writeback wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 4 | Addressing-mode code |
| size_i | input | 2 | Operand size: 0 byte, 1 word, 2 long |
| reg_sel_i | input | 3 | Base address register number |
| idx_sel_i | input | 4 | Index register select |
| ext_i | input | 24 | Extension word: displacement or absolute address |
| pc_i | input | 24 | Current program counter |
| done_i | input | 1 | Operand access completes this cycle |
| ld_en_i | input | 1 | Register load strobe |
| ld_sel_i | input | 4 | Register load target |
| ld_data_i | input | 24 | Register load value |
| ea_o | output | 24 | Effective address |
| mem_o | output | 1 | Address refers to memory |
| wb_en_o | output | 1 | Address register writeback strobe |
| wb_reg_o | output | 3 | Writeback register number |
| wb_val_o | output | 24 | Writeback value |

## Verification
The assertions assume the mode, size and select inputs are known and held steady through each cycle. They also assume `done_i` may be raised in any mode, not just the updating ones. The stimulus changes all inputs only at the falling edge and draws mode codes across the whole 4-bit range, including unused codes. It raises `done_i` and `ld_en_i` in random mixes, so loads and writebacks collide on the same register as well as on different ones. Size code 3 is left out of the random stream, so every step checked is one of the three defined sizes.

// File: rtl/eagu_pkg.sv
package eagu_pkg;
  typedef enum logic [3:0] {
    M_IMM     = 4'd0,
    M_ABS_L   = 4'd1,
    M_ABS_S   = 4'd2,
    M_REG     = 4'd3,
    M_IND     = 4'd4,
    M_POSTINC = 4'd5,
    M_PREDEC  = 4'd6,
    M_IDX16   = 4'd7,
    M_IDX8    = 4'd8,
    M_PC16    = 4'd9,
    M_PC8     = 4'd10
  } mode_e;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_W = 2'd1,
    SZ_L = 2'd2,
    SZ_X = 2'd3
  } size_e;
endpackage

// File: rtl/eagu_regfile.sv
module eagu_regfile #(
  parameter int AW   = 24,
  parameter int NREG = 8,
  localparam int RSW = $clog2(NREG)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [RSW-1:0] a_sel_i,
  output logic [AW-1:0]  a_o,
  input  logic [RSW:0]   x_sel_i,
  output logic [AW-1:0]  x_o,
  input  logic           wb_en_i,
  input  logic [RSW-1:0] wb_sel_i,
  input  logic [AW-1:0]  wb_val_i,
  input  logic           ld_en_i,
  input  logic [RSW:0]   ld_sel_i,
  input  logic [AW-1:0]  ld_data_i
);
  logic [NREG-1:0][AW-1:0] a_q;
  logic [NREG-1:0][AW-1:0] d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      d_q <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        // load port has priority over writeback
        if (ld_en_i && ld_sel_i == {1'b0, RSW'(i)})
          a_q[i] <= ld_data_i;
        else if (wb_en_i && wb_sel_i == RSW'(i))
          a_q[i] <= wb_val_i;
        if (ld_en_i && ld_sel_i == {1'b1, RSW'(i)})
          d_q[i] <= ld_data_i;
      end
    end
  end

  assign a_o = a_q[a_sel_i];
  assign x_o = x_sel_i[RSW] ? d_q[x_sel_i[RSW-1:0]] : a_q[x_sel_i[RSW-1:0]];

  // R10: writeback lands unless a load targets the same register
  a_r10_wb_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_i && !(ld_en_i && ld_sel_i == {1'b0, wb_sel_i})
    |=> a_q[$past(wb_sel_i)] == $past(wb_val_i));

  // R11: a load to an address register always lands
  a_r11_ld_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_en_i && !ld_sel_i[RSW] |=> a_q[$past(ld_sel_i[RSW-1:0])] == $past(ld_data_i));

  // R4: with no write strobe the file is frozen
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wb_en_i && !ld_en_i |=> $stable(a_q) && $stable(d_q));
endmodule

// File: rtl/eagu_calc.sv
module eagu_calc
  import eagu_pkg::*;
#(
  parameter int AW  = 24,
  parameter int D16 = 16,
  parameter int D8  = 8
) (
  input  logic [3:0]    mode_i,
  input  logic [1:0]    size_i,
  input  logic [AW-1:0] an_i,
  input  logic [AW-1:0] xr_i,
  input  logic [AW-1:0] ext_i,
  input  logic [AW-1:0] pc_i,
  output logic [AW-1:0] ea_o,
  output logic          mem_o,
  output logic          upd_o,
  output logic [AW-1:0] wbv_o
);
  logic [AW-1:0] step, sx16, sx8;

  always_comb begin
    unique case (size_e'(size_i))
      SZ_B:    step = AW'(1);
      SZ_W:    step = AW'(2);
      default: step = AW'(4);
    endcase
  end

  assign sx16 = {{(AW-D16){ext_i[D16-1]}}, ext_i[D16-1:0]};
  assign sx8  = {{(AW-D8){ext_i[D8-1]}}, ext_i[D8-1:0]};

  always_comb begin
    ea_o  = '0;
    mem_o = 1'b1;
    upd_o = 1'b0;
    wbv_o = '0;
    case (mode_i)
      M_ABS_L: ea_o = ext_i;
      M_ABS_S: ea_o = sx16;
      M_IND:   ea_o = an_i;
      M_POSTINC: begin
        ea_o  = an_i;
        wbv_o = an_i + step;
        upd_o = 1'b1;
      end
      M_PREDEC: begin
        ea_o  = an_i - step;
        wbv_o = an_i - step;
        upd_o = 1'b1;
      end
      M_IDX16: ea_o = an_i + sx16;
      M_IDX8:  ea_o = an_i + sx8 + xr_i;
      M_PC16:  ea_o = pc_i + sx16;
      M_PC8:   ea_o = pc_i + sx8 + xr_i;
      default: mem_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/eagu_top.sv
module eagu_top
  import eagu_pkg::*;
#(
  parameter int AW   = 24,
  parameter int NREG = 8,
  localparam int RSW = $clog2(NREG)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [3:0]     mode_i,
  input  logic [1:0]     size_i,
  input  logic [RSW-1:0] reg_sel_i,
  input  logic [RSW:0]   idx_sel_i,
  input  logic [AW-1:0]  ext_i,
  input  logic [AW-1:0]  pc_i,
  input  logic           done_i,
  input  logic           ld_en_i,
  input  logic [RSW:0]   ld_sel_i,
  input  logic [AW-1:0]  ld_data_i,
  output logic [AW-1:0]  ea_o,
  output logic           mem_o,
  output logic           wb_en_o,
  output logic [RSW-1:0] wb_reg_o,
  output logic [AW-1:0]  wb_val_o
);
  logic [AW-1:0] an, xr;
  logic          upd;

  eagu_regfile #(.AW(AW), .NREG(NREG)) u_rf (
    .clk_i, .rst_ni,
    .a_sel_i  (reg_sel_i),
    .a_o      (an),
    .x_sel_i  (idx_sel_i),
    .x_o      (xr),
    .wb_en_i  (wb_en_o),
    .wb_sel_i (reg_sel_i),
    .wb_val_i (wb_val_o),
    .ld_en_i, .ld_sel_i, .ld_data_i
  );

  eagu_calc #(.AW(AW)) u_calc (
    .mode_i, .size_i,
    .an_i  (an),
    .xr_i  (xr),
    .ext_i, .pc_i,
    .ea_o, .mem_o,
    .upd_o (upd),
    .wbv_o (wb_val_o)
  );

  assign wb_en_o  = upd & done_i;
  assign wb_reg_o = reg_sel_i;

  a_r2_no_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_IMM || mode_i == M_REG || mode_i > M_PC8)
    |-> !mem_o && ea_o == '0 && !wb_en_o);

  a_r3_short_sext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == M_ABS_S |-> ea_o[AW-1:16] == {(AW-16){ea_o[15]}});

  a_r5_post_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == M_POSTINC |-> (wb_val_o - ea_o) ==
      (size_i == SZ_B ? AW'(1) : size_i == SZ_W ? AW'(2) : AW'(4)));

  a_r6_pre_same: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == M_PREDEC |-> wb_val_o == ea_o);

  a_r10_wb_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> done_i && (mode_i == M_POSTINC || mode_i == M_PREDEC));
endmodule

// File: tb/tb_eagu_top.sv
module tb_eagu_top;
  import eagu_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  mode_i = '0;
  logic [1:0]  size_i = '0;
  logic [2:0]  reg_sel_i = '0;
  logic [3:0]  idx_sel_i = '0;
  logic [23:0] ext_i = '0, pc_i = '0;
  logic        done_i = 1'b0, ld_en_i = 1'b0;
  logic [3:0]  ld_sel_i = '0;
  logic [23:0] ld_data_i = '0;
  logic [23:0] ea_o, wb_val_o;
  logic        mem_o, wb_en_o;
  logic [2:0]  wb_reg_o;

  int checks = 0, errors = 0;
  logic [23:0] am [8];
  logic [23:0] dm [8];

  always #2.5 clk_i = ~clk_i;

  eagu_top dut (.*);

  function automatic logic [23:0] sx(input logic [23:0] v, input int bits);
    int t;
    t = int'(v) & ((1 << bits) - 1);
    if (t >= (1 << (bits - 1))) t = t - (1 << bits);
    return 24'(t);
  endfunction

  function automatic string tag_of(input logic [3:0] m);
    case (m)
      4'd1, 4'd2: return "R3";
      4'd4:       return "R4";
      4'd5:       return "R5";
      4'd6:       return "R6";
      4'd7, 4'd9: return "R7";
      4'd8, 4'd10: return "R8";
      default:    return "R2";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive at negedge, compare mid-cycle, update model on the next rising edge
  task automatic cyc(input logic [3:0] m, input logic [1:0] sz, input logic [2:0] rs,
                     input logic [3:0] xs, input logic [23:0] ex, input logic [23:0] p,
                     input logic dn, input logic le, input logic [3:0] ls,
                     input logic [23:0] ld, input string tag);
    int st;
    logic [23:0] an, xr, e, w;
    logic mm, up;
    mode_i = m; size_i = sz; reg_sel_i = rs; idx_sel_i = xs; ext_i = ex; pc_i = p;
    done_i = dn; ld_en_i = le; ld_sel_i = ls; ld_data_i = ld;
    #1;
    st = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    an = am[rs];
    xr = xs[3] ? dm[xs[2:0]] : am[xs[2:0]];
    e = '0; w = '0; mm = 1'b1; up = 1'b0;
    case (m)
      4'd1:  e = ex;
      4'd2:  e = sx(ex, 16);
      4'd4:  e = an;
      4'd5:  begin e = an; w = 24'(int'(an) + st); up = 1'b1; end
      4'd6:  begin e = 24'(int'(an) - st); w = e; up = 1'b1; end
      4'd7:  e = an + sx(ex, 16);
      4'd8:  e = an + sx(ex, 8) + xr;
      4'd9:  e = p + sx(ex, 16);
      4'd10: e = p + sx(ex, 8) + xr;
      default: mm = 1'b0;
    endcase
    chk(tag, "ea", {8'h0, ea_o}, {8'h0, e});
    chk(tag, "mem", {31'h0, mem_o}, {31'h0, mm});
    chk(dn && up ? "R10" : tag, "wb_en", {31'h0, wb_en_o}, {31'h0, dn && up});
    if (up) begin
      chk(tag, "wb_val", {8'h0, wb_val_o}, {8'h0, w});
      chk("R10", "wb_reg", {29'h0, wb_reg_o}, {29'h0, rs});
    end
    @(posedge clk_i);
    if (dn && up) am[rs] = w;
    if (le) begin
      if (ls[3]) dm[ls[2:0]] = ld;
      else am[ls[2:0]] = ld;
    end
    @(negedge clk_i);
  endtask

  task automatic load(input logic [3:0] ls, input logic [23:0] v);
    cyc(4'd0, 2'd0, 3'd0, 4'd0, 24'h0, 24'h0, 1'b0, 1'b1, ls, v, "R11");
  endtask

  initial begin
    #(5.0 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin am[i] = '0; dm[i] = '0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: all registers zero after reset
    for (int i = 0; i < 8; i++)
      cyc(4'd8, 2'd0, 3'(i), {1'b1, 3'(i)}, 24'h0, 24'h0, 1'b0, 1'b0, 4'h0, 24'h0, "R1");

    // R2: immediate, register and unused codes
    cyc(4'd0, 2'd2, 3'd1, 4'd0, 24'h123456, 24'h10, 1'b1, 1'b0, 4'h0, 24'h0, "R2");
    cyc(4'd3, 2'd2, 3'd1, 4'd0, 24'h123456, 24'h10, 1'b1, 1'b0, 4'h0, 24'h0, "R2");
    cyc(4'd15, 2'd2, 3'd1, 4'd0, 24'h123456, 24'h10, 1'b1, 1'b0, 4'h0, 24'h0, "R2");

    // R3: absolute long and short with both signs
    cyc(4'd1, 2'd1, 3'd0, 4'd0, 24'hABCDEF, 24'h0, 1'b0, 1'b0, 4'h0, 24'h0, "R3");
    cyc(4'd2, 2'd1, 3'd0, 4'd0, 24'h00F000, 24'h0, 1'b0, 1'b0, 4'h0, 24'h0, "R3");
    cyc(4'd2, 2'd1, 3'd0, 4'd0, 24'hFF7000, 24'h0, 1'b0, 1'b0, 4'h0, 24'h0, "R3");

    // R11: loads, and load beats writeback on the same register
    load(4'h2, 24'h001000);
    load(4'hA, 24'h000020);
    load(4'h7, 24'hFFFFFF);
    cyc(4'd5, 2'd2, 3'd2, 4'd0, 24'h0, 24'h0, 1'b1, 1'b1, 4'h2, 24'h005555, "R11");
    cyc(4'd4, 2'd0, 3'd2, 4'd0, 24'h0, 24'h0, 1'b0, 1'b0, 4'h0, 24'h0, "R11");

    // R4/R5/R6/R10: indirect, post-increment, pre-decrement, gating
    cyc(4'd4, 2'd0, 3'd2, 4'd0, 24'h0, 24'h0, 1'b1, 1'b0, 4'h0, 24'h0, "R4");
    cyc(4'd5, 2'd1, 3'd2, 4'd0, 24'h0, 24'h0, 1'b0, 1'b0, 4'h0, 24'h0, "R10");
    cyc(4'd5, 2'd0, 3'd2, 4'd0, 24'h0, 24'h0, 1'b1, 1'b0, 4'h0, 24'h0, "R5");
    cyc(4'd5, 2'd1, 3'd2, 4'd0, 24'h0, 24'h0, 1'b1, 1'b0, 4'h0, 24'h0, "R5");
    cyc(4'd5, 2'd2, 3'd2, 4'd0, 24'h0, 24'h0, 1'b1, 1'b0, 4'h0, 24'h0, "R5");
    cyc(4'd6, 2'd2, 3'd2, 4'd0, 24'h0, 24'h0, 1'b1, 1'b0, 4'h0, 24'h0, "R6");
    cyc(4'd4, 2'd0, 3'd2, 4'd0, 24'h0, 24'h0, 1'b0, 1'b0, 4'h0, 24'h0, "R6");

    // R9: wrap at both ends
    cyc(4'd5, 2'd2, 3'd7, 4'd0, 24'h0, 24'h0, 1'b1, 1'b0, 4'h0, 24'h0, "R9");
    cyc(4'd6, 2'd2, 3'd0, 4'd0, 24'h0, 24'h0, 1'b1, 1'b0, 4'h0, 24'h0, "R9");
    cyc(4'd9, 2'd0, 3'd0, 4'd0, 24'h008000, 24'h000010, 1'b0, 1'b0, 4'h0, 24'h0, "R9");

    // R7/R8: displacement and index forms
    cyc(4'd7, 2'd0, 3'd2, 4'd0, 24'h00FFF0, 24'h0, 1'b0, 1'b0, 4'h0, 24'h0, "R7");
    cyc(4'd8, 2'd0, 3'd2, 4'hA, 24'h0000F0, 24'h0, 1'b0, 1'b0, 4'h0, 24'h0, "R8");
    cyc(4'd10, 2'd0, 3'd0, 4'h2, 24'h00007F, 24'h400000, 1'b0, 1'b0, 4'h0, 24'h0, "R8");

    // random mix, all codes, colliding loads and writebacks
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] m;
      m = 4'($urandom % 16);
      cyc(m, 2'($urandom % 3), 3'($urandom), 4'($urandom), 24'($urandom), 24'($urandom),
          1'($urandom), ($urandom % 4) == 0, 4'($urandom), 24'($urandom), tag_of(m));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule